// File: doc/BRIEF.md
# Exclusive Two-Level Tag Placement Dispatcher

This block sits in front of a private cache hierarchy. It keeps three small direct-mapped tag stores: a first-level instruction array, a first-level data array and a second-level array. A line lives in at most one of the three. Each cycle it looks at the pending processor request and emits exactly one action. The action is either a terminal outcome (local access, coherence miss, deferral, error) or one tag-move step (promotion, demotion, eviction). The block also performs the tag move in that same cycle.

A request stays presented until `req_ready_o` rises. After every move step the same request is evaluated again in the next cycle, so a request that lands in the wrong first-level array, or that needs a victim moved out of the way, resolves over several cycles.

Each tag entry carries a small coherence state field, and that field travels with the line. The coherence machinery is outside this block. It is seen only through `busy_i`, which marks a line as being in a transient state, and through a state-write port.

Top module: `xplace_disp`

## Requirements
- R1: After reset all three arrays are empty. A cycle with `req_valid_i` low gives act code 0 (none) with `req_ready_o` low. The first request to any line gives code 5 (miss).
- R2: A line address is held in at most one of the instruction, data and second-level arrays at any time.
- R3: Request type 0 (load) takes path 0, type 1 (fetch) takes path 1, and types 2 (store) and 3 (atomic) take path 2. Types 4 to 7 give code 7 (error), complete the request and change no array.
- R4: For a fetch, the other first-level array is the data array; for a load, store or atomic, it is the instruction array. If the requested line sits in that other array, the action is code 3 (demote), moving that line into second-level set `addr mod L2_SETS` when that slot is invalid. When the slot is occupied, the action is code 4 (evict) of the slot's occupant.
- R5: A hit in the request's own first-level array gives code 1 (access). `act_state_o` then carries the line's stored state, and the request completes.
- R6: When the own first-level set `addr mod L1_SETS` is invalid, a second-level hit gives code 2 (promote). The promote moves the line from level two into that set. Otherwise the action is code 5 (miss), which allocates the set with state 0.
- R7: When the own first-level set holds a different line, that victim is demoted (code 3) into second-level set `victim mod L2_SETS` if that slot is invalid. Otherwise the slot's occupant is evicted (code 4).
- R8: If `busy_i` is high in a cycle whose action would be 2, 3 or 4, the action becomes code 6 (defer). The request completes, no array changes, and `act_addr_o` is the request address.
- R9: The coherence state moves with the line on promote and demote. A state write with `req_valid_i` low updates the line wherever it is held. A state write with `req_valid_i` high is ignored.
- R10: `req_ready_o` is high exactly for codes 1, 5, 6 and 7. For codes 2, 3 and 4 the request is held and evaluated again next cycle. For those codes `act_addr_o` and `act_state_o` name the moved or evicted line. For codes 5, 6 and 7 `act_state_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_type_i | input | 3 | Request type (0 load, 1 fetch, 2 store, 3 atomic) |
| req_addr_i | input | LINE_AW | Line address of the request |
| busy_i | input | 1 | Line in transient coherence state; blocks tag moves |
| coh_we_i | input | 1 | Coherence state write strobe |
| coh_addr_i | input | LINE_AW | Line whose state is written |
| coh_state_i | input | ST_W | New coherence state |
| req_ready_o | output | 1 | Request resolved this cycle |
| act_code_o | output | 3 | Action code |
| act_addr_o | output | LINE_AW | Line the action applies to |
| act_path_o | output | 2 | Access path (0 load, 1 fetch, 2 store) |
| act_state_o | output | ST_W | Coherence state of the named line |

## Verification
Some properties are checked on every cycle:
- exclusion of the request line across the three arrays;
- the idle output when no request is presented;
- the error code for unknown types;
- a defer only ever appearing with `busy_i` high;
- a miss being followed by an access when the same request is presented again.

The bench scenarios cover the rest. These are the multi-step chains (wrong-array demote followed by promote, eviction before a victim demote), the state following a line through moves, and a state write ignored while a request is present. They also show that a deferred move left the arrays untouched.

// File: rtl/xplace_pkg.sv
package xplace_pkg;
  parameter int LINE_AW = 16;
  parameter int ST_W    = 2;

  typedef struct packed {
    logic               vld;
    logic [LINE_AW-1:0] addr;
    logic [ST_W-1:0]    st;
  } tag_ent_t;

  typedef enum logic [2:0] {
    ACT_NONE    = 3'd0,
    ACT_ACCESS  = 3'd1,
    ACT_PROMOTE = 3'd2,
    ACT_DEMOTE  = 3'd3,
    ACT_EVICT   = 3'd4,
    ACT_MISS    = 3'd5,
    ACT_DEFER   = 3'd6,
    ACT_ERROR   = 3'd7
  } act_e;

  localparam logic [1:0] ARR_I    = 2'd0;
  localparam logic [1:0] ARR_D    = 2'd1;
  localparam logic [1:0] ARR_L2   = 2'd2;
  localparam logic [1:0] ARR_NONE = 2'd3;

  localparam logic [2:0] RQ_LOAD   = 3'd0;
  localparam logic [2:0] RQ_FETCH  = 3'd1;
  localparam logic [2:0] RQ_STORE  = 3'd2;
  localparam logic [2:0] RQ_ATOMIC = 3'd3;

  localparam logic [1:0] PATH_STORE = 2'd2;
endpackage

// File: rtl/xplace_tag_array.sv
module xplace_tag_array
  import xplace_pkg::*;
#(
  parameter int SETS = 8,
  parameter int IW   = 4,
  parameter int NRD  = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NRD-1:0][IW-1:0]    rd_idx_i,
  output tag_ent_t [NRD-1:0]        rd_ent_o,
  input  logic                      we_i,
  input  logic [IW-1:0]             widx_i,
  input  tag_ent_t                  wdata_i
);
  // SETS must be a power of two no larger than 2**IW
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1;

  tag_ent_t mem [SETS];

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_ent_o[g] = mem[rd_idx_i[g][SW-1:0]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) mem[s] <= '0;
    end else if (we_i) begin
      mem[widx_i[SW-1:0]] <= wdata_i;
    end
  end
endmodule

// File: rtl/xplace_classify.sv
module xplace_classify
  import xplace_pkg::*;
#(
  parameter int IW1 = 3,
  parameter int IW2 = 4,
  parameter int IW  = 4
) (
  input  logic               req_valid_i,
  input  logic [2:0]         req_type_i,
  input  logic [LINE_AW-1:0] req_addr_i,
  input  logic               busy_i,
  input  tag_ent_t           ent_i_i,
  input  tag_ent_t           ent_d_i,
  input  tag_ent_t           l2_req_i,
  input  tag_ent_t           l2_vic_i,
  input  logic               hit_i_i,
  input  logic               hit_d_i,
  input  logic               hit_l2_i,
  output logic [IW-1:0]      vic_idx_o,
  output act_e               code_o,
  output logic [LINE_AW-1:0] addr_o,
  output logic [1:0]         path_o,
  output logic [ST_W-1:0]    st_o,
  output logic [1:0]         clr_arr_o,
  output logic [IW-1:0]      clr_idx_o,
  output logic [1:0]         set_arr_o,
  output logic [IW-1:0]      set_idx_o,
  output tag_ent_t           set_ent_o
);
  logic          is_fetch, own_hit, oth_hit;
  tag_ent_t      own_e, oth_e;
  logic [1:0]    own_arr, oth_arr;
  logic [IW-1:0] i1, i2r;

  assign is_fetch  = (req_type_i == RQ_FETCH);
  assign own_e     = is_fetch ? ent_i_i : ent_d_i;
  assign oth_e     = is_fetch ? ent_d_i : ent_i_i;
  assign own_hit   = is_fetch ? hit_i_i : hit_d_i;
  assign oth_hit   = is_fetch ? hit_d_i : hit_i_i;
  assign own_arr   = is_fetch ? ARR_I : ARR_D;
  assign oth_arr   = is_fetch ? ARR_D : ARR_I;
  assign i1        = IW'(req_addr_i[IW1-1:0]);
  assign i2r       = IW'(req_addr_i[IW2-1:0]);
  assign vic_idx_o = IW'(own_e.addr[IW2-1:0]);

  always_comb begin
    code_o    = ACT_NONE;
    addr_o    = req_addr_i;
    path_o    = '0;
    st_o      = '0;
    clr_arr_o = ARR_NONE;
    clr_idx_o = '0;
    set_arr_o = ARR_NONE;
    set_idx_o = '0;
    set_ent_o = '0;
    if (req_valid_i) begin
      if (req_type_i > RQ_ATOMIC) begin
        code_o = ACT_ERROR;
      end else begin
        path_o = (req_type_i >= RQ_STORE) ? PATH_STORE : req_type_i[1:0];
        if (oth_hit) begin
          // wrong first-level array: push line down before access
          if (!l2_req_i.vld) begin
            code_o = ACT_DEMOTE;  st_o = oth_e.st;
            clr_arr_o = oth_arr;  clr_idx_o = i1;
            set_arr_o = ARR_L2;   set_idx_o = i2r;  set_ent_o = oth_e;
          end else begin
            code_o = ACT_EVICT;   addr_o = l2_req_i.addr;  st_o = l2_req_i.st;
            clr_arr_o = ARR_L2;   clr_idx_o = i2r;
          end
        end else if (own_hit) begin
          code_o = ACT_ACCESS;
          st_o   = own_e.st;
        end else if (!own_e.vld) begin
          if (hit_l2_i) begin
            code_o = ACT_PROMOTE; st_o = l2_req_i.st;
            clr_arr_o = ARR_L2;   clr_idx_o = i2r;
            set_arr_o = own_arr;  set_idx_o = i1;  set_ent_o = l2_req_i;
          end else begin
            code_o = ACT_MISS;
            set_arr_o = own_arr;  set_idx_o = i1;
            set_ent_o = '{vld: 1'b1, addr: req_addr_i, st: '0};
          end
        end else if (!l2_vic_i.vld) begin
          code_o = ACT_DEMOTE;  addr_o = own_e.addr;  st_o = own_e.st;
          clr_arr_o = own_arr;  clr_idx_o = i1;
          set_arr_o = ARR_L2;   set_idx_o = vic_idx_o;  set_ent_o = own_e;
        end else begin
          code_o = ACT_EVICT;   addr_o = l2_vic_i.addr;  st_o = l2_vic_i.st;
          clr_arr_o = ARR_L2;   clr_idx_o = vic_idx_o;
        end
        if (busy_i && (code_o inside {ACT_PROMOTE, ACT_DEMOTE, ACT_EVICT})) begin
          code_o    = ACT_DEFER;
          addr_o    = req_addr_i;
          st_o      = '0;
          clr_arr_o = ARR_NONE;
          set_arr_o = ARR_NONE;
        end
      end
    end
  end
endmodule

// File: rtl/xplace_disp.sv
module xplace_disp
  import xplace_pkg::*;
#(
  parameter int L1_SETS = 8,
  parameter int L2_SETS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [2:0]         req_type_i,
  input  logic [LINE_AW-1:0] req_addr_i,
  input  logic               busy_i,
  input  logic               coh_we_i,
  input  logic [LINE_AW-1:0] coh_addr_i,
  input  logic [ST_W-1:0]    coh_state_i,
  output logic               req_ready_o,
  output logic [2:0]         act_code_o,
  output logic [LINE_AW-1:0] act_addr_o,
  output logic [1:0]         act_path_o,
  output logic [ST_W-1:0]    act_state_o
);
  localparam int IW1 = (L1_SETS > 1) ? $clog2(L1_SETS) : 1;
  localparam int IW2 = (L2_SETS > 1) ? $clog2(L2_SETS) : 1;
  localparam int IW  = (IW1 > IW2) ? IW1 : IW2;
  localparam int NARR = 3;

  tag_ent_t [1:0] rd_i, rd_d;
  tag_ent_t [2:0] rd_l2;
  tag_ent_t       ent_req [NARR];
  tag_ent_t       ent_coh [NARR];
  logic [IW-1:0]  coh_idx [NARR];
  logic [IW-1:0]  req_i1, req_i2, vic_idx;
  logic [2:0]     hit_vec;
  logic [NARR-1:0] coh_hit;

  logic           we    [NARR];
  logic [IW-1:0]  widx  [NARR];
  tag_ent_t       wdata [NARR];

  act_e           code;
  logic [1:0]     clr_arr, set_arr;
  logic [IW-1:0]  clr_idx, set_idx;
  tag_ent_t       set_ent;

  assign req_i1     = IW'(req_addr_i[IW1-1:0]);
  assign req_i2     = IW'(req_addr_i[IW2-1:0]);
  assign coh_idx[0] = IW'(coh_addr_i[IW1-1:0]);
  assign coh_idx[1] = IW'(coh_addr_i[IW1-1:0]);
  assign coh_idx[2] = IW'(coh_addr_i[IW2-1:0]);

  xplace_tag_array #(.SETS(L1_SETS), .IW(IW), .NRD(2)) u_arr_i (
    .clk_i, .rst_ni, .rd_idx_i({coh_idx[0], req_i1}), .rd_ent_o(rd_i),
    .we_i(we[0]), .widx_i(widx[0]), .wdata_i(wdata[0]));
  xplace_tag_array #(.SETS(L1_SETS), .IW(IW), .NRD(2)) u_arr_d (
    .clk_i, .rst_ni, .rd_idx_i({coh_idx[1], req_i1}), .rd_ent_o(rd_d),
    .we_i(we[1]), .widx_i(widx[1]), .wdata_i(wdata[1]));
  xplace_tag_array #(.SETS(L2_SETS), .IW(IW), .NRD(3)) u_arr_l2 (
    .clk_i, .rst_ni, .rd_idx_i({coh_idx[2], vic_idx, req_i2}), .rd_ent_o(rd_l2),
    .we_i(we[2]), .widx_i(widx[2]), .wdata_i(wdata[2]));

  assign ent_req[0] = rd_i[0];
  assign ent_req[1] = rd_d[0];
  assign ent_req[2] = rd_l2[0];
  assign ent_coh[0] = rd_i[1];
  assign ent_coh[1] = rd_d[1];
  assign ent_coh[2] = rd_l2[2];

  for (genvar k = 0; k < NARR; k++) begin : g_hit
    assign hit_vec[k] = ent_req[k].vld && (ent_req[k].addr == req_addr_i);
    assign coh_hit[k] = ent_coh[k].vld && (ent_coh[k].addr == coh_addr_i);
  end

  xplace_classify #(.IW1(IW1), .IW2(IW2), .IW(IW)) u_classify (
    .req_valid_i, .req_type_i, .req_addr_i, .busy_i,
    .ent_i_i(ent_req[0]), .ent_d_i(ent_req[1]),
    .l2_req_i(rd_l2[0]), .l2_vic_i(rd_l2[1]),
    .hit_i_i(hit_vec[0]), .hit_d_i(hit_vec[1]), .hit_l2_i(hit_vec[2]),
    .vic_idx_o(vic_idx), .code_o(code), .addr_o(act_addr_o),
    .path_o(act_path_o), .st_o(act_state_o),
    .clr_arr_o(clr_arr), .clr_idx_o(clr_idx),
    .set_arr_o(set_arr), .set_idx_o(set_idx), .set_ent_o(set_ent));

  // tag moves own the write ports; state writes only when no request
  always_comb begin
    tag_ent_t upd;
    for (int k = 0; k < NARR; k++) begin
      we[k]    = 1'b0;
      widx[k]  = '0;
      wdata[k] = '0;
      upd      = ent_coh[k];
      upd.st   = coh_state_i;
      if (set_arr == 2'(k)) begin
        we[k] = 1'b1;  widx[k] = set_idx;  wdata[k] = set_ent;
      end else if (clr_arr == 2'(k)) begin
        we[k] = 1'b1;  widx[k] = clr_idx;
      end else if (coh_we_i && !req_valid_i && coh_hit[k]) begin
        we[k] = 1'b1;  widx[k] = coh_idx[k];  wdata[k] = upd;
      end
    end
  end

  assign act_code_o  = code;
  assign req_ready_o = (code == ACT_ACCESS) || (code == ACT_MISS) ||
                       (code == ACT_DEFER)  || (code == ACT_ERROR);
endmodule

// File: rtl/xplace_disp_chk.sv
module xplace_disp_chk
  import xplace_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [2:0]         req_type_i,
  input logic [LINE_AW-1:0] req_addr_i,
  input logic               busy_i,
  input logic [2:0]         act_code_o,
  input logic [2:0]         hit_vec
);
  a_r2_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hit_vec) <= 1);

  a_r1_idle_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> act_code_o == ACT_NONE);

  a_r3_bad_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_type_i > RQ_ATOMIC) |-> act_code_o == ACT_ERROR);

  a_r8_defer_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_code_o == ACT_DEFER |-> busy_i);

  a_r6_miss_then_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && act_code_o == ACT_MISS) |=>
      (!req_valid_i || req_addr_i != $past(req_addr_i) ||
       req_type_i != $past(req_type_i) || act_code_o == ACT_ACCESS));
endmodule

bind xplace_disp xplace_disp_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_type_i(req_type_i), .req_addr_i(req_addr_i), .busy_i(busy_i),
  .act_code_o(act_code_o), .hit_vec(hit_vec));

// File: tb/xplace_disp_bench.sv
module xplace_disp_bench;
  localparam int AW = 16, SW = 2, L1S = 8, L2S = 16;
  localparam int C_NONE = 0, C_ACC = 1, C_PRO = 2, C_DEM = 3, C_EVI = 4,
                 C_MISS = 5, C_DEF = 6, C_ERR = 7;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, busy_i = 1'b0, coh_we_i = 1'b0;
  logic [2:0] req_type_i = '0;
  logic [AW-1:0] req_addr_i = '0, coh_addr_i = '0;
  logic [SW-1:0] coh_state_i = '0;
  logic req_ready_o;
  logic [2:0] act_code_o;
  logic [AW-1:0] act_addr_o;
  logic [1:0] act_path_o;
  logic [SW-1:0] act_state_o;

  always #10 clk = ~clk;  // 20 ns period

  xplace_disp #(.L1_SETS(L1S), .L2_SETS(L2S)) u_xplace_disp (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_type_i, .req_addr_i, .busy_i,
    .coh_we_i, .coh_addr_i, .coh_state_i, .req_ready_o, .act_code_o,
    .act_addr_o, .act_path_o, .act_state_o);

  int n_cmp = 0, n_bad = 0;
  bit mv [3][L2S];
  logic [AW-1:0] ma [3][L2S];
  int ms [3][L2S];
  int seen[$], seen_st[$];

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // reference: requirement rules applied to a bench-side copy of the arrays
  function automatic void mdl(input int t, input logic [AW-1:0] a, input bit b,
                              output int c, output logic [AW-1:0] oa,
                              output int os, output int op, output string rq);
    int own, oth, i1, i2, j;
    logic [AW-1:0] v;
    c = C_NONE; oa = a; os = 0; op = 0; rq = "R10";
    if (t > 3) begin c = C_ERR; rq = "R3"; return; end
    op = (t >= 2) ? 2 : t;
    own = (t == 1) ? 0 : 1; oth = 1 - own;
    i1 = int'(a % L1S); i2 = int'(a % L2S);
    if (mv[oth][i1] && ma[oth][i1] == a) begin
      rq = "R4";
      if (!mv[2][i2]) begin
        c = C_DEM; os = ms[oth][i1];
        if (!b) begin mv[2][i2] = 1; ma[2][i2] = a; ms[2][i2] = ms[oth][i1]; mv[oth][i1] = 0; end
      end else begin
        c = C_EVI; oa = ma[2][i2]; os = ms[2][i2];
        if (!b) mv[2][i2] = 0;
      end
    end else if (mv[own][i1] && ma[own][i1] == a) begin
      c = C_ACC; os = ms[own][i1]; rq = "R5";
    end else if (!mv[own][i1]) begin
      rq = "R6";
      if (mv[2][i2] && ma[2][i2] == a) begin
        c = C_PRO; os = ms[2][i2];
        if (!b) begin mv[own][i1] = 1; ma[own][i1] = a; ms[own][i1] = ms[2][i2]; mv[2][i2] = 0; end
      end else begin
        c = C_MISS; mv[own][i1] = 1; ma[own][i1] = a; ms[own][i1] = 0;
      end
    end else begin
      rq = "R7"; v = ma[own][i1]; j = int'(v % L2S);
      if (!mv[2][j]) begin
        c = C_DEM; oa = v; os = ms[own][i1];
        if (!b) begin mv[2][j] = 1; ma[2][j] = v; ms[2][j] = ms[own][i1]; mv[own][i1] = 0; end
      end else begin
        c = C_EVI; oa = ma[2][j]; os = ms[2][j];
        if (!b) mv[2][j] = 0;
      end
    end
    if (b && (c == C_PRO || c == C_DEM || c == C_EVI)) begin
      c = C_DEF; oa = a; os = 0; rq = "R8";
    end
  endfunction

  task automatic do_req(input int t, input logic [AW-1:0] a, input bit b,
                        input bit cw, input logic [AW-1:0] ca, input int cs);
    seen.delete(); seen_st.delete();
    for (int s = 0; s < 12; s++) begin
      int c, os, op;
      logic [AW-1:0] oa;
      string rq;
      bit term;
      @(negedge clk);
      req_valid_i = 1; req_type_i = t[2:0]; req_addr_i = a; busy_i = b;
      coh_we_i = cw; coh_addr_i = ca; coh_state_i = cs[SW-1:0];
      #5;
      mdl(t, a, b, c, oa, os, op, rq);
      seen.push_back(int'(act_code_o)); seen_st.push_back(int'(act_state_o));
      chk(int'(act_code_o) == c, rq, "code", act_code_o, c);
      chk(act_addr_o == oa, rq, "addr", act_addr_o, oa);
      chk(int'(act_state_o) == os, rq, "state", act_state_o, os);
      if (c == C_ACC || c == C_MISS) chk(int'(act_path_o) == op, "R3", "path", act_path_o, op);
      term = (c == C_ACC) || (c == C_MISS) || (c == C_DEF) || (c == C_ERR);
      chk(req_ready_o == term, "R10", "ready", req_ready_o, term);
      if (term) break;
      if (s == 11) chk(0, "R10", "step limit", s, 11);
    end
    @(negedge clk);
    req_valid_i = 0; busy_i = 0; coh_we_i = 0;
    #5;
    chk(int'(act_code_o) == C_NONE, "R1", "idle code", act_code_o, C_NONE);
  endtask

  task automatic coh_idle(input logic [AW-1:0] a, input int st);
    @(negedge clk);
    req_valid_i = 0; coh_we_i = 1; coh_addr_i = a; coh_state_i = st[SW-1:0];
    for (int k = 0; k < 3; k++) begin
      int ix;
      ix = (k == 2) ? int'(a % L2S) : int'(a % L1S);
      if (mv[k][ix] && ma[k][ix] == a) ms[k][ix] = st;
    end
    #5;
    chk(req_ready_o == 1'b0, "R1", "idle ready", req_ready_o, 0);
    @(negedge clk);
    coh_we_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h1d2c));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk); #5;
    chk(int'(act_code_o) == C_NONE, "R1", "reset code", act_code_o, C_NONE);
    chk(req_ready_o == 1'b0, "R1", "reset ready", req_ready_o, 0);

    do_req(0, 16'h05, 0, 0, 0, 0);
    chk(seen[0] == C_MISS, "R1", "first reference", seen[0], C_MISS);
    do_req(0, 16'h05, 0, 0, 0, 0);
    chk(seen[0] == C_ACC, "R5", "own hit", seen[0], C_ACC);
    coh_idle(16'h05, 2);
    do_req(1, 16'h05, 0, 0, 0, 0);  // wrong array: demote, promote, access
    chk(seen.size() == 3, "R4", "step count", seen.size(), 3);
    chk(seen[0] == C_DEM, "R4", "wrong array demote", seen[0], C_DEM);
    chk(seen[1] == C_PRO, "R6", "promote", seen[1], C_PRO);
    chk(seen_st[2] == 2, "R9", "state carried", seen_st[2], 2);
    do_req(0, 16'h05, 1, 0, 0, 0);
    chk(seen[0] == C_DEF, "R8", "busy defers", seen[0], C_DEF);
    do_req(0, 16'h05, 0, 0, 0, 0);
    chk(seen[0] == C_DEM, "R8", "deferred move left line", seen[0], C_DEM);
    do_req(5, 16'h05, 0, 0, 0, 0);
    chk(seen[0] == C_ERR, "R3", "unknown type", seen[0], C_ERR);
    do_req(3, 16'h05, 0, 1, 16'h05, 3);  // state write during request ignored
    do_req(0, 16'h05, 0, 0, 0, 0);
    chk(seen_st[0] == 2, "R9", "busy-cycle write ignored", seen_st[0], 2);
    do_req(0, 16'h0D, 0, 0, 0, 0);
    chk(seen[0] == C_DEM, "R7", "victim demote", seen[0], C_DEM);
    do_req(0, 16'h15, 0, 0, 0, 0);
    do_req(0, 16'h25, 0, 0, 0, 0);
    chk(seen[0] == C_EVI, "R7", "victim slot evict", seen[0], C_EVI);

    for (int n = 0; n < 800; n++) begin
      int t, a;
      bit b;
      t = ($urandom % 16 < 2) ? 4 + int'($urandom % 4) : int'($urandom % 4);
      a = int'($urandom % 48);
      b = ($urandom % 8) == 0;
      if ($urandom % 4 == 0) coh_idle(16'(int'($urandom % 48)), int'($urandom % 4));
      do_req(t, 16'(a), b, 0, 0, 0);
    end
    finish_run();
  end
endmodule